// File: doc/BRIEF.md
# Video Line Framer with Embedded Sync Codes

The framer accepts 32-bit words, each holding one 4:2:2 sample group (Cb, Y0, Cr, Y1 from the low byte upward) or four raw VBI samples. It places them on an output bus that is either one byte lane (narrow mode) or two byte lanes (wide mode). A start-of-line code goes ahead of the first word of every line that carries data, and an end-of-line code follows the word that is marked as the last of its line. A line that delivers no words produces no codes at all. The number of words per line is free, and so is the gap between lines.

A downstream slot enable (`out_en`) sets the output cadence, and that cadence may be irregular. Data units leave only in enabled slots. A code that has started runs to the end on back-to-back cycles. Cycles that carry nothing have `out_dv` low. In qualifier mode the bus shows the all-zero filler in those cycles. In gated-clock mode `out_dv` serves as the clock enable, and the bus keeps its last value. Field (F) and vertical-blanking (V) flags are taken from the first word of each line.

Top module: `vidport_framer`

## Requirements
- R1: While reset is asserted and after it, with no input, `out_dv` is 0, `out_data` is 0 and `in_ready` is 1.
- R2: A line's first word causes a start code of four units before any of its data: all-ones, zero, zero, then XY. XY is 1,F,V,H,(V^H),(F^H),(F^V),(F^V^H) from the MSB down, with H=0.
- R3: After the data of a word flagged `in_eol`, an end code (the same form with H=1) is emitted before any later start code.
- R4: When no word is offered, no code and no data unit appear. A line of N words produces exactly N data words between its two codes.
- R5: Narrow mode sends each word as bits [7:0], [15:8], [23:16], [31:24] in that order on `out_data[7:0]`, with the upper lane zero. Code units also use the low lane only.
- R6: Wide mode sends each word as `in_dword[15:0]` and then `in_dword[31:16]`, so the low lane carries chrominance and the high lane luminance. Each code unit is placed on both lanes, and a code takes four cycles.
- R7: A data unit appears on the bus the cycle after a cycle with `out_en` high, and never after a cycle with `out_en` low. Unit order is kept across gaps in `out_en` and `in_valid`.
- R8: Once the first unit of a code has appeared, the other three appear on the next three cycles, whatever `out_en` does.
- R9: With `cfg_gated`=0, every cycle with `out_dv` low shows all-zero data.
- R10: With `cfg_gated`=1, `out_dv` marks the same units, and `out_data` keeps its previous value on every cycle with `out_dv` low.
- R11: Both codes of a line use the F and V flags of that line's first word. Flags on the later words of the line are ignored.
- R12: A word is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the holding register is empty, or when the last unit of the held word leaves in this cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1: two-lane bus, 0: one lane |
| cfg_gated | input | 1 | 1: qualifier is a clock enable and the bus holds between units |
| out_en | input | 1 | Downstream slot enable |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken |
| in_dword | input | 32 | Sample group Cb,Y0,Cr,Y1 from the low byte upward |
| in_eol | input | 1 | This word is the last of its line |
| in_field | input | 1 | Field flag (used on a line's first word) |
| in_vbi | input | 1 | Vertical blanking flag (used on a line's first word) |
| out_data | output | 16 | Output bus, low lane [7:0] |
| out_dv | output | 1 | Unit valid / clock enable |

## Verification
The hardest situation to reach is a code that begins just before a run of disabled slots, while the input is also starved. A bench with the enable always high cannot tell a code that runs without a break from one that waits for enabled slots. The irregular scenarios therefore drive `out_en` low on two incommensurate periods (every third and every seventh cycle) and gate `in_valid` on a third period. Codes then start at many phases relative to the gaps. The bench checks that each code's four units fall on consecutive cycles and that every data unit follows an enabled slot.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SAV  = 2'd1,
      ST_DATA = 2'd2,
      ST_EAV  = 2'd3
   } vpf_state_e;

   // Code flag byte: 1,F,V,H then protection bits
   function automatic logic [7:0] vpf_xy(input logic f, input logic v, input logic h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

endpackage

// File: rtl/vpf_hold.sv
module vpf_hold #(
   parameter int DW_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [DW_W-1:0] in_dword,
   input  logic            in_eol,
   input  logic            in_fld,
   input  logic            in_vbi,
   input  logic            take_last,
   output logic            in_ready,
   output logic            have,
   output logic [DW_W-1:0] dw_q,
   output logic            eol_q,
   output logic            fld_q,
   output logic            vbi_q
);

   logic load;

   assign in_ready = !have || take_last;
   assign load     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have  <= 1'b0;
         dw_q  <= '0;
         eol_q <= 1'b0;
         fld_q <= 1'b0;
         vbi_q <= 1'b0;
      end else if (load) begin
         have  <= 1'b1;
         dw_q  <= in_dword;
         eol_q <= in_eol;
         fld_q <= in_fld;
         vbi_q <= in_vbi;
      end else if (take_last) begin
         have  <= 1'b0;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (have && !take_last) |=> (have && $stable(dw_q))); // R12

endmodule

// File: rtl/vpf_unit_mux.sv
module vpf_unit_mux
   import vpf_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic                wide,
   input  logic                is_code,
   input  logic [1:0]          cidx,
   input  logic                cf,
   input  logic                cv,
   input  logic                ch,
   input  logic [4*LANE_W-1:0] dw,
   input  logic [1:0]          phase,
   output logic [2*LANE_W-1:0] unit
);

   localparam int NLANE = 4;

   logic [LANE_W-1:0] lane [NLANE];
   logic [LANE_W-1:0] code_b;
   logic [LANE_W-1:0] xy_full;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane[g] = dw[g*LANE_W +: LANE_W];
   end

   // XY sits in the top 8 bits of a lane; lower bits are zero
   assign xy_full = LANE_W'(vpf_xy(cf, cv, ch)) << (LANE_W - 8);

   always_comb begin
      unique case (cidx)
         2'd0:    code_b = '1;
         2'd3:    code_b = xy_full;
         default: code_b = '0;
      endcase
   end

   always_comb begin
      if (is_code) begin
         unit = wide ? {code_b, code_b} : {{LANE_W{1'b0}}, code_b};
      end else if (wide) begin
         unit = phase[0] ? {lane[3], lane[2]} : {lane[1], lane[0]};
      end else begin
         unit = {{LANE_W{1'b0}}, lane[phase]};
      end
   end

endmodule

// File: rtl/vidport_framer.sv
module vidport_framer
   import vpf_pkg::*;
#(
   parameter int LANE_W = 8,
   localparam int DW_W  = 4 * LANE_W,
   localparam int OUT_W = 2 * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wide,
   input  logic             cfg_gated,
   input  logic             out_en,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [DW_W-1:0]  in_dword,
   input  logic             in_eol,
   input  logic             in_field,
   input  logic             in_vbi,
   output logic [OUT_W-1:0] out_data,
   output logic             out_dv
);

   initial begin
      assert (LANE_W >= 8) else $error("LANE_W must be at least 8");
   end

   vpf_state_e state, state_n;
   logic [1:0] cidx, cidx_n, phase, phase_n;
   logic       line_f, line_v, tail, tail_n;
   logic       have, hold_eol, hold_fld, hold_vbi;
   logic [DW_W-1:0] hold_dw;
   logic       emit, is_code, code_h, take_last;
   logic       cf, cv;
   logic [1:0] unit_cidx, last_phase;
   logic [OUT_W-1:0] unit;

   vpf_hold #(.DW_W(DW_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_dword  (in_dword),
      .in_eol    (in_eol),
      .in_fld    (in_field),
      .in_vbi    (in_vbi),
      .take_last (take_last),
      .in_ready  (in_ready),
      .have      (have),
      .dw_q      (hold_dw),
      .eol_q     (hold_eol),
      .fld_q     (hold_fld),
      .vbi_q     (hold_vbi)
   );

   assign last_phase = cfg_wide ? 2'd1 : 2'd3;
   assign cf = (state == ST_IDLE) ? hold_fld : line_f;
   assign cv = (state == ST_IDLE) ? hold_vbi : line_v;

   always_comb begin
      state_n   = state;
      cidx_n    = cidx;
      phase_n   = phase;
      tail_n    = tail;
      emit      = 1'b0;
      is_code   = 1'b0;
      code_h    = 1'b0;
      unit_cidx = cidx;
      take_last = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (have && out_en) begin
               emit      = 1'b1;
               is_code   = 1'b1;
               unit_cidx = 2'd0;
               cidx_n    = 2'd1;
               state_n   = ST_SAV;
            end
         end
         ST_SAV, ST_EAV: begin
            emit    = 1'b1;
            is_code = 1'b1;
            code_h  = (state == ST_EAV);
            cidx_n  = cidx + 2'd1;
            if (cidx == 2'd3) begin
               state_n = (state == ST_SAV) ? ST_DATA : ST_IDLE;
               phase_n = 2'd0;
               tail_n  = 1'b0;
            end
         end
         ST_DATA: begin
            if (out_en && tail) begin
               emit      = 1'b1;
               is_code   = 1'b1;
               code_h    = 1'b1;
               unit_cidx = 2'd0;
               cidx_n    = 2'd1;
               state_n   = ST_EAV;
            end else if (out_en && have) begin
               emit = 1'b1;
               if (phase == last_phase) begin
                  phase_n   = 2'd0;
                  take_last = 1'b1;
                  tail_n    = hold_eol;
               end else begin
                  phase_n = phase + 2'd1;
               end
            end
         end
         default: state_n = ST_IDLE;
      endcase
   end

   vpf_unit_mux #(.LANE_W(LANE_W)) u_mux (
      .wide    (cfg_wide),
      .is_code (is_code),
      .cidx    (unit_cidx),
      .cf      (cf),
      .cv      (cv),
      .ch      (code_h),
      .dw      (hold_dw),
      .phase   (phase),
      .unit    (unit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cidx     <= 2'd0;
         phase    <= 2'd0;
         tail     <= 1'b0;
         line_f   <= 1'b0;
         line_v   <= 1'b0;
         out_dv   <= 1'b0;
         out_data <= '0;
      end else begin
         state <= state_n;
         cidx  <= cidx_n;
         phase <= phase_n;
         tail  <= tail_n;
         if (state == ST_IDLE && state_n == ST_SAV) begin
            line_f <= hold_fld;
            line_v <= hold_vbi;
         end
         out_dv <= emit;
         if (emit)            out_data <= unit;
         else if (!cfg_gated) out_data <= '0;
      end
   end

   AST_CODE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SAV || state == ST_EAV) |=> out_dv); // R8
   AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_gated |=> (out_dv || out_data == '0)); // R9
   AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_gated |=> (out_dv || $stable(out_data))); // R10
   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !have) |=> !out_dv); // R4
   AST_SLOT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && !out_en) |=> !out_dv); // R7

endmodule

// File: tb/vidport_framer_tb.sv
module vidport_framer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wide = 1'b0, cfg_gated = 1'b0, out_en = 1'b0;
   logic        in_valid = 1'b0, in_eol = 1'b0, in_field = 1'b0, in_vbi = 1'b0;
   logic [31:0] in_dword = '0;
   logic        in_ready, out_dv;
   logic [15:0] out_data;

   int checks = 0, errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   vidport_framer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_gated(cfg_gated),
      .out_en(out_en), .in_valid(in_valid), .in_ready(in_ready),
      .in_dword(in_dword), .in_eol(in_eol), .in_field(in_field), .in_vbi(in_vbi),
      .out_data(out_data), .out_dv(out_dv)
   );

   // stimulus and expectation storage
   logic [31:0] tx_dw [16];
   bit          tx_eol [16], tx_f [16], tx_v [16];
   int          n_tx;
   logic [15:0] exp_u [128];
   bit          exp_code [128], exp_cstart [128];
   int          n_exp;
   logic [15:0] got_u [256];
   bit          got_en [256];
   int          got_cyc [256];
   int          n_got;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic push_code(input bit wide, input bit f, input bit v, input bit h);
      for (int i = 0; i < 4; i++) begin
         logic [7:0] b;
         b = (i == 0) ? 8'hFF : (i == 3) ? xy(f, v, h) : 8'h00;
         exp_u[n_exp] = wide ? {b, b} : {8'h00, b};
         exp_code[n_exp] = 1;
         exp_cstart[n_exp] = (i == 0);
         n_exp++;
      end
   endtask

   // first word carries the line flags; later words carry the opposite flags (R11)
   task automatic add_line(input bit wide, input int ndw, input bit f, input bit v);
      push_code(wide, f, v, 1'b0);
      for (int d = 0; d < ndw; d++) begin
         logic [7:0] s;
         s = 8'(16 * n_tx + 1);
         tx_dw[n_tx]  = {s + 8'd3, s + 8'd2, s + 8'd1, s};
         tx_eol[n_tx] = (d == ndw - 1);
         tx_f[n_tx]   = (d == 0) ? f : !f;
         tx_v[n_tx]   = (d == 0) ? v : !v;
         if (wide) begin
            exp_u[n_exp] = tx_dw[n_tx][15:0];  exp_code[n_exp] = 0; exp_cstart[n_exp] = 0; n_exp++;
            exp_u[n_exp] = tx_dw[n_tx][31:16]; exp_code[n_exp] = 0; exp_cstart[n_exp] = 0; n_exp++;
         end else begin
            for (int b = 0; b < 4; b++) begin
               exp_u[n_exp] = {8'h00, tx_dw[n_tx][8*b +: 8]};
               exp_code[n_exp] = 0; exp_cstart[n_exp] = 0; n_exp++;
            end
         end
         n_tx++;
      end
      push_code(wide, f, v, 1'b1);
   endtask

   // drives the stream, records outputs, then compares against expectations
   task automatic run_and_check(input string name, input bit irregular);
      int k = 0, cyc = 0, extra = 0, fill_bad = 0;
      bit prev_en = 0;
      logic [15:0] last_d;
      n_got = 0;
      last_d = out_data;
      while (cyc < 3000 && extra < 8) begin
         @(negedge clk);
         cyc++;
         if (out_dv) begin
            if (n_got < 256) begin
               got_u[n_got] = out_data; got_en[n_got] = prev_en; got_cyc[n_got] = cyc;
            end
            n_got++;
         end else if (cfg_gated ? (out_data != last_d) : (out_data != 16'h0)) begin
            fill_bad++;
         end
         last_d = out_data;
         out_en   = irregular ? !((cyc % 3) == 1 || (cyc % 7) == 0) : 1'b1;
         in_valid = (k < n_tx) && (irregular ? !((cyc % 5) == 2 || (cyc % 40) >= 30) : 1'b1);
         if (k < n_tx) begin
            in_dword = tx_dw[k]; in_eol = tx_eol[k]; in_field = tx_f[k]; in_vbi = tx_v[k];
         end
         #1;
         if (in_valid && in_ready) k++;
         prev_en = out_en;
         if (k == n_tx && n_got >= n_exp) extra++;
      end
      in_valid = 0; out_en = 0;
      chk(n_got == n_exp, "R4", {name, " unit count"}, n_got, n_exp);
      chk(fill_bad == 0, cfg_gated ? "R10" : "R9", {name, " idle bus"}, fill_bad, 0);
      for (int j = 0; j < n_exp && j < n_got && j < 256; j++) begin
         chk(got_u[j] == exp_u[j], exp_code[j] ? "R2/R3" : (cfg_wide ? "R6" : "R5"),
             $sformatf("%s unit %0d", name, j), got_u[j], exp_u[j]);
         if (!exp_code[j])
            chk(got_en[j], "R7", $sformatf("%s data unit %0d slot", name, j), got_en[j], 1);
         if (exp_cstart[j] && j + 3 < n_got)
            chk(got_cyc[j + 3] == got_cyc[j] + 3, "R8", $sformatf("%s code at %0d span", name, j),
                got_cyc[j + 3] - got_cyc[j], 3);
      end
   endtask

   task automatic reset_test();
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(out_dv == 0, "R1", "dv in reset", out_dv, 0);
      chk(out_data == 0, "R1", "data in reset", out_data, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(in_ready == 1, "R1", "ready after reset", in_ready, 1);
      chk(out_dv == 0, "R1", "dv after reset", out_dv, 0);
   endtask

   task automatic t_byte_basic();   // R2 R3 R5
      cfg_wide = 0; cfg_gated = 0; n_tx = 0; n_exp = 0;
      add_line(0, 2, 1'b0, 1'b0);
      chk(exp_u[3] == 16'h0080, "R2", "model SAV F0V0", exp_u[3], 16'h0080);
      run_and_check("byte_basic", 0);
   endtask

   task automatic t_wide_basic();   // R6 R11
      cfg_wide = 1; cfg_gated = 0; n_tx = 0; n_exp = 0;
      add_line(1, 3, 1'b1, 1'b0);
      run_and_check("wide_basic", 0);
   endtask

   task automatic t_irregular();    // R4 R7 R8 R11 R12
      cfg_wide = 0; cfg_gated = 0; n_tx = 0; n_exp = 0;
      add_line(0, 1, 1'b1, 1'b1);
      add_line(0, 4, 1'b0, 1'b1);
      add_line(0, 2, 1'b1, 1'b0);
      run_and_check("byte_irregular", 1);
   endtask

   task automatic t_gated();        // R10 R6 R7
      cfg_wide = 1; cfg_gated = 1; n_tx = 0; n_exp = 0;
      add_line(1, 3, 1'b0, 1'b0);
      add_line(1, 2, 1'b1, 1'b1);
      run_and_check("wide_gated", 1);
   endtask

   initial begin
      reset_test();
      t_byte_basic();
      t_wide_basic();
      t_irregular();
      t_gated();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog timeout");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule